// File: doc/BRIEF.md
# Flash completion status poller

This block runs on the host side of a parallel NOR flash. It waits for an embedded program or erase operation inside the flash to finish. A one-cycle start pulse gives it the kind of operation, the expected data word and the address to poll. The block then issues single read cycles on a request/acknowledge read port and checks the status bits in each returned word. Bit 7 is the completion flag: it reads as inverted data until the operation finishes. Bit 5 is the exceeded-time flag.

Bit 7 can settle before the rest of the word, and it can change independently of bit 5. For this reason the block never stops on the first read that looks complete. A read that shows bit 7 complete is followed by one confirming read, and the block returns that word. A read that shows bit 5 set is followed by a second look at bit 7 before the block reports an error. The operation ends with a one-cycle done pulse that carries a pass or timeout result and the last word read.

Top module: `nor_done_poller`

## Requirements
- R1: While rstN is low and in the first cycle after its release, rdReq, busy and done are all 0.
- R2: A startReq sampled while idle sets busy from the next cycle. Busy stays high up to and including the done cycle and is 0 in the cycle after done. Every read cycle of the operation uses the address given with the start.
- R3: Program operation (startErase = 0): a read counts as complete when its bit 7 equals bit 7 of startData.
- R4: Erase operation (startErase = 1): a read counts as complete when its bit 7 is 1, whatever startData holds.
- R5: A read that is not complete and has bit 5 = 0 is followed by another polling read.
- R6: A read that is not complete and has bit 5 = 1 is followed by exactly one recheck read. If the recheck is complete, the block goes on to a confirming read. If it is not, the block ends with a timeout and issues no further read.
- R7: When a read is complete, the block issues one more (confirming) read and then ends with a pass. The word returned by that confirming read is presented on doneData.
- R8: done is high for exactly one cycle per operation. In that cycle, result is 0 for pass and 1 for timeout, and doneData holds the word of the last read.
- R9: A startReq that arrives while busy is high has no effect on the address, the operation type, the number of reads or the result of the operation in progress.
- R10: rdReq and rdAddr hold steady until rdAck is sampled high. The read word is taken from rdData in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | One-cycle request to begin polling |
| startErase | input | 1 | 1 = erase operation, 0 = program operation |
| startData | input | DATA_W | Data being programmed (its bit 7 is the reference) |
| startAddr | input | ADDR_W | Address to poll |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | ADDR_W | Read address |
| rdAck | input | 1 | Read acknowledge; rdData is valid in this cycle |
| rdData | input | DATA_W | Word returned by the flash |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| result | output | 1 | 0 = pass, 1 = timeout; valid with done |
| doneData | output | DATA_W | Word from the last read; valid with done |

## Verification
The assertions assume that rdAck is raised only while rdReq is high, that each acknowledge lasts one cycle, and that rdData is valid in that cycle. They also assume that startReq is a single-cycle pulse. The bench's read responder answers only a pending request, after a programmable wait. It drops rdAck in the cycle after each acknowledge and serves scripted status words in request order. The bench raises startReq for one cycle at a time, and it raises it during busy only on purpose, to exercise the rule that such a start is ignored.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHECK,
    ST_CONFIRM,
    ST_FINISH
  } poll_state_t;

  typedef struct packed {
    logic loadCmd;
    logic capture;
    logic setPass;
    logic setFail;
  } poll_strobe_t;

endpackage

// File: rtl/nor_poll_ctrl.sv
module nor_poll_ctrl
  import nor_poll_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         rdAck,
  input  logic         bitMatch,
  input  logic         limitHit,
  output poll_strobe_t strb,
  output logic         rdReq,
  output logic         busy,
  output logic         done
);

  poll_state_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.loadCmd = 1'b1;
          stateNxt     = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rdAck) begin
          strb.capture = 1'b1;
          if (bitMatch)      stateNxt = ST_CONFIRM;
          else if (limitHit) stateNxt = ST_RECHECK;
          else               stateNxt = ST_POLL;
        end
      end
      ST_RECHECK: begin
        if (rdAck) begin
          strb.capture = 1'b1;
          if (bitMatch) begin
            stateNxt = ST_CONFIRM;
          end else begin
            strb.setFail = 1'b1;
            stateNxt     = ST_FINISH;
          end
        end
      end
      ST_CONFIRM: begin
        if (rdAck) begin
          strb.capture = 1'b1;
          strb.setPass = 1'b1;
          stateNxt     = ST_FINISH;
        end
      end
      ST_FINISH: stateNxt = ST_IDLE;
      default:   stateNxt = ST_IDLE;
    endcase
  end

  assign rdReq = (state == ST_POLL) || (state == ST_RECHECK) || (state == ST_CONFIRM);
  assign busy  = (state != ST_IDLE);
  assign done  = (state == ST_FINISH);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq);  // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);  // R8
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(rdAck));  // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdReq);  // R2

endmodule

// File: rtl/nor_poll_dp.sv
module nor_poll_dp
  import nor_poll_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 8,
  parameter int DONE_BIT = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  poll_strobe_t      strb,
  input  logic              startErase,
  input  logic [DATA_W-1:0] startData,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              bitMatch,
  output logic              limitHit,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              result,
  output logic [DATA_W-1:0] doneData
);

  localparam logic [DATA_W-1:0] DONE_MASK = DATA_W'(1) << DONE_BIT;

  logic              eraseOp;
  logic [DATA_W-1:0] expWord;
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wordReg;
  logic              resultReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseOp <= 1'b0;
      expWord <= '0;
      addrReg <= '0;
    end else if (strb.loadCmd) begin
      eraseOp <= startErase;
      expWord <= startData;
      addrReg <= startAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wordReg <= '0;
    else if (strb.capture) wordReg <= rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             resultReg <= 1'b0;
    else if (strb.setFail) resultReg <= 1'b1;
    else if (strb.setPass) resultReg <= 1'b0;
  end

  // Erase finishes when the flag bit reads 1; program when it equals the reference.
  generate
    if (DONE_BIT < DATA_W) begin : g_match
      assign bitMatch = eraseOp ? rdData[DONE_BIT]
                                : (((rdData ^ expWord) & DONE_MASK) == '0);
    end else begin : g_nomatch
      assign bitMatch = 1'b0;
    end
  endgenerate

  assign limitHit = rdData[LIMIT_BIT];
  assign rdAddr   = addrReg;
  assign result   = resultReg;
  assign doneData = wordReg;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadCmd, strb.setPass, strb.setFail}));  // R8
  AST_ENDS_WITH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setPass || strb.setFail) |-> strb.capture);  // R7

endmodule

// File: rtl/nor_done_poller.sv
module nor_done_poller
  import nor_poll_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 8,
  parameter int DONE_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              startErase,
  input  logic [DATA_W-1:0] startData,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              result,
  output logic [DATA_W-1:0] doneData
);

  poll_strobe_t strb;
  logic         bitMatch;
  logic         limitHit;

  nor_poll_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .rdAck    (rdAck),
    .bitMatch (bitMatch),
    .limitHit (limitHit),
    .strb     (strb),
    .rdReq    (rdReq),
    .busy     (busy),
    .done     (done)
  );

  nor_poll_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DONE_BIT  (DONE_BIT),
    .LIMIT_BIT (LIMIT_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .startErase (startErase),
    .startData  (startData),
    .startAddr  (startAddr),
    .rdData     (rdData),
    .bitMatch   (bitMatch),
    .limitHit   (limitHit),
    .rdAddr     (rdAddr),
    .result     (result),
    .doneData   (doneData)
  );

  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(rdAddr));  // R9
  AST_REQ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> $stable(rdAddr));  // R10
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);  // R2

endmodule

// File: tb/nor_done_poller_bench.sv
module nor_done_poller_bench;

  localparam int AW = 21;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic          startErase = 1'b0;
  logic [DW-1:0] startData = '0;
  logic [AW-1:0] startAddr = '0;
  logic          rdReq;
  logic [AW-1:0] rdAddr;
  logic          rdAck = 1'b0;
  logic [DW-1:0] rdData = '0;
  logic          busy, done, result;
  logic [DW-1:0] doneData;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [DW-1:0] script [0:15];
  int            scriptBase = 0;
  int            readCnt = 0;
  int            badAddr = 0;
  int            ackDelay = 0;
  int            waitCnt = 0;
  logic [AW-1:0] expAddr = '0;

  always #10 clk = ~clk;

  nor_done_poller u_nor_done_poller (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startErase(startErase),
    .startData(startData), .startAddr(startAddr), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData), .busy(busy), .done(done), .result(result),
    .doneData(doneData)
  );

  // Read responder: answers a pending request after ackDelay idle cycles.
  always @(negedge clk) begin
    if (rdAck) begin
      rdAck = 1'b0;
      waitCnt = 0;
    end else if (rdReq) begin
      if (waitCnt >= ackDelay) begin
        int idx;
        idx = readCnt - scriptBase;
        if (idx < 0 || idx > 15) idx = 15;
        rdData = script[idx];
        if (rdAddr !== expAddr) badAddr++;
        readCnt++;
        rdAck = 1'b1;
        waitCnt = 0;
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runPoll(input logic erase, input logic [DW-1:0] expd,
                         input logic [AW-1:0] addr, input bit intrude,
                         input int expReads, input logic expRes,
                         input logic [DW-1:0] expWord, input string tag);
    bit got;
    int base;
    int bad0;
    @(negedge clk);
    base = readCnt;
    scriptBase = readCnt;
    bad0 = badAddr;
    expAddr = addr;
    startErase = erase;
    startData = expd;
    startAddr = addr;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy === 1'b1, {tag, " R2 busy after start"}, busy, 1);
    got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      if (intrude && i == 2) begin
        startReq = 1'b1;
        startErase = ~erase;
        startData = ~expd;
        startAddr = addr ^ 21'h1F0F;
      end else begin
        startReq = 1'b0;
      end
      @(negedge clk);
    end
    startReq = 1'b0;
    check(got, {tag, " R8 done seen"}, got, 1);
    check(result === expRes, {tag, " R8 result"}, result, expRes);
    check(doneData === expWord, {tag, " R7 doneData"}, doneData, expWord);
    check(readCnt - base == expReads, {tag, " read count"}, readCnt - base, expReads);
    check(badAddr == bad0, {tag, " R2 read address"}, badAddr - bad0, 0);
    check(busy === 1'b1, {tag, " R2 busy with done"}, busy, 1);
    @(negedge clk);
    check(done === 1'b0, {tag, " R8 done one cycle"}, done, 0);
    check(busy === 1'b0 && rdReq === 1'b0, {tag, " R2 idle after done"}, {busy, rdReq}, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(rdReq === 0 && busy === 0 && done === 0, "R1 outputs in reset",
          {rdReq, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rdReq === 0 && busy === 0 && done === 0, "R1 outputs after release",
          {rdReq, busy, done}, 0);
  endtask

  // R3 and R5: program, reference bit 1, two not-ready reads then match.
  task automatic testProgramHigh();
    ackDelay = 0;
    script[0] = 8'h05; script[1] = 8'h05; script[2] = 8'h85; script[3] = 8'hA5;
    runPoll(1'b0, 8'hA5, 21'h01234, 1'b0, 4, 1'b0, 8'hA5, "R3/R5 prog high");
  endtask

  // R3: program, reference bit 0, read with bit 7 = 1 is not ready.
  task automatic testProgramLow();
    ackDelay = 1;
    script[0] = 8'h80; script[1] = 8'h3C; script[2] = 8'h3C;
    runPoll(1'b0, 8'h3C, 21'h1FFFF, 1'b0, 3, 1'b0, 8'h3C, "R3 prog low");
  endtask

  // R4 and R6: erase, limit flag seen, recheck shows completion.
  task automatic testEraseRecheckPass();
    ackDelay = 0;
    script[0] = 8'h40; script[1] = 8'h7F; script[2] = 8'hFF; script[3] = 8'hFF;
    runPoll(1'b1, 8'h00, 21'h10000, 1'b0, 4, 1'b0, 8'hFF, "R4/R6 erase recheck pass");
  endtask

  // R6: erase, limit flag seen, recheck still not ready gives timeout.
  task automatic testEraseTimeout();
    ackDelay = 2;
    script[0] = 8'h20; script[1] = 8'h24; script[2] = 8'hFF;
    runPoll(1'b1, 8'hFF, 21'h00ABC, 1'b0, 2, 1'b1, 8'h24, "R6 erase timeout");
  endtask

  // R6: program timeout; bit 5 ignored once bit 7 matches.
  task automatic testProgramTimeout();
    ackDelay = 0;
    script[0] = 8'h00; script[1] = 8'h20; script[2] = 8'h00; script[3] = 8'hA0;
    runPoll(1'b0, 8'h80, 21'h00777, 1'b0, 3, 1'b1, 8'h00, "R6 prog timeout");
  endtask

  // R6 and R7: program where the first read shows both completion and bit 5.
  task automatic testMatchWithLimit();
    ackDelay = 0;
    script[0] = 8'hA0; script[1] = 8'h9A;
    runPoll(1'b0, 8'h9A, 21'h00100, 1'b0, 2, 1'b0, 8'h9A, "R7 match beats limit");
  endtask

  // R9 and R10: start during polling is ignored; slow acknowledges.
  task automatic testIntrudingStart();
    ackDelay = 3;
    script[0] = 8'h00; script[1] = 8'h00; script[2] = 8'h00;
    script[3] = 8'h80; script[4] = 8'h81;
    runPoll(1'b1, 8'h00, 21'h0AAAA, 1'b1, 5, 1'b0, 8'h81, "R9/R10 start while busy");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) script[i] = 8'hFF;
    testReset();
    testProgramHigh();
    testProgramLow();
    testEraseRecheckPass();
    testEraseTimeout();
    testProgramTimeout();
    testMatchWithLimit();
    testIntrudingStart();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule